// File: doc/BRIEF.md
# Two-Stage Serial Baud Tick Generator

This block derives the two timing strobes that a serial transmitter and receiver need from one reference clock. An optional fixed divide-by-eight front stage can slow the reference first. A programmable 16-bit clock divisor then turns the selected clock into a sample strobe. A programmable 8-bit bit divisor counts sample strobes and marks the end of each bit period. The bit rate is therefore the selected clock divided by the product of the clock divisor and one more than the bit divisor.

Both strobes are registered and last one reference clock cycle. Whenever any of the three configuration inputs changes, every counter restarts from zero on the next edge. A change therefore gives the same timing as a reset, and the output never carries a partial period from the old setting. The surrounding logic should change the settings only while its transmitter and receiver are idle.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `sample_tick` and `bit_tick` are low after that edge. All counters start from zero, so the first `sample_tick` appears exactly one sample period after the last reset edge.
- R2: With `pre_div8` = 0 and `clk_div` = N (N >= 2), `sample_tick` is high after every edge whose count since the restart edge is a multiple of N, and low after every other edge.
- R3: With `pre_div8` = 1, the sample period becomes 8*N cycles, with the first strobe exactly 8*N cycles after the restart edge.
- R4: `bit_tick` is high on every (`bit_div`+1)-th `sample_tick`, counted from the restart edge, in the same cycle as that sample strobe, and never without one. `bit_div` = 0 gives a bit strobe on every sample strobe.
- R5: Each strobe is one cycle wide, including the fastest setting `clk_div` = 2 with no prescaler, where `sample_tick` alternates high and low.
- R6: A `clk_div` value of 0 or 1 stops the sample strobe and the bit strobe. Both stay low for as long as the value is held.
- R7: A change of `clk_div`, `bit_div` or `pre_div8` restarts every counter at the next edge. No strobe follows that edge, and the later timing matches R2 to R4 counted from that edge.
- R8: The end values work: `bit_div` = 255 gives 256 sample strobes per bit, and `clk_div` = 65535 gives a sample period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_div8 | input | 1 | 1 selects the divide-by-8 front stage, 0 uses the reference directly |
| clk_div | input | 16 | Clock divisor; selected clock cycles per sample strobe |
| bit_div | input | 8 | Sample strobes per bit, minus one |
| sample_tick | output | 1 | One-cycle sample strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with the last sample strobe of a bit |

## Verification
The bench compares the full strobe pattern cycle by cycle against a period computed from the settings. An off-by-one in the divisor compare would shift every strobe by one cycle. A prescaler that only divides by seven would show up in the 8*N spacing. It changes each setting in the middle of a count. A design that only reloaded at a wrap would produce its first strobe early or late, and one that ignored a bit-divisor change would keep the old bit grouping. It also holds the divisor at 0 and 1, where a careless compare against N-1 would wrap and strobe, and it runs the widest and fastest settings, where an overflowing bit counter would drop the bit strobe.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CLK_DIV_W_DEF = 16;
  localparam int BIT_DIV_W_DEF = 8;
  localparam int PRE_RATIO_DEF = 8;
  localparam int MIN_CLK_DIV   = 2;

  function automatic int cnt_width(input int span);
    return (span > 1) ? $clog2(span) : 1;
  endfunction
endpackage

// File: rtl/baud_cfg_watch.sv
module baud_cfg_watch
  import baud_pkg::*;
#(
  parameter int CDW = CLK_DIV_W_DEF,
  parameter int BDW = BIT_DIV_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_in,
  input  logic [CDW-1:0] cd_in,
  input  logic [BDW-1:0] bd_in,
  output logic           sel_q,
  output logic [CDW-1:0] cd_q,
  output logic [BDW-1:0] bd_q,
  output logic           restart
);
  localparam int CFG_W = 1 + CDW + BDW;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_held;

  assign cfg_now = {sel_in, cd_in, bd_in};

  // shadow copy of the settings; refreshed every cycle
  always_ff @(posedge clk) begin
    cfg_held <= cfg_now;
  end

  assign {sel_q, cd_q, bd_q} = cfg_held;
  assign restart = !rst && (cfg_now != cfg_held);
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
  import baud_pkg::*;
#(
  parameter int RATIO = PRE_RATIO_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic sel,
  output logic pre_en
);
  generate
    if (RATIO > 1) begin : g_div
      localparam int PW = cnt_width(RATIO);
      localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk) begin
        if (rst || restart)  pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
      end

      assign pre_en = sel ? (pcnt == LAST) : 1'b1;

      // R3: a divided enable is never followed directly by another
      assert_pre_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (pre_en && sel && !restart) |=> (!pre_en || restart));
    end else begin : g_pass
      assign pre_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div
  import baud_pkg::*;
#(
  parameter int CDW = CLK_DIV_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           pre_en,
  input  logic [CDW-1:0] cd_q,
  output logic           strobe,
  output logic           tick
);
  localparam logic [CDW-1:0] MIN_CD = CDW'(MIN_CLK_DIV);
  localparam logic [CDW-1:0] ONE    = CDW'(1);

  logic [CDW-1:0] ccnt;
  logic           cd_ok;
  logic           at_last;

  assign cd_ok   = (cd_q >= MIN_CD);
  assign at_last = (ccnt == cd_q - ONE);
  assign strobe  = !restart && pre_en && cd_ok && at_last;

  always_ff @(posedge clk) begin
    if (rst || restart)       ccnt <= '0;
    else if (pre_en && cd_ok) ccnt <= at_last ? '0 : ccnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= strobe;
  end

  // R5: the registered sample strobe is never two cycles long
  assert_tick_narrow_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div
  import baud_pkg::*;
#(
  parameter int BDW = BIT_DIV_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           strobe,
  input  logic [BDW-1:0] bd_q,
  output logic           tick
);
  logic [BDW-1:0] bcnt;
  logic           at_end;

  assign at_end = (bcnt == bd_q);

  always_ff @(posedge clk) begin
    if (rst || restart) bcnt <= '0;
    else if (strobe)    bcnt <= at_end ? '0 : bcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= strobe && at_end;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int CDW   = CLK_DIV_W_DEF,
  parameter int BDW   = BIT_DIV_W_DEF,
  parameter int RATIO = PRE_RATIO_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_div8,
  input  logic [CDW-1:0] clk_div,
  input  logic [BDW-1:0] bit_div,
  output logic           sample_tick,
  output logic           bit_tick
);
  logic           sel_q;
  logic [CDW-1:0] cd_q;
  logic [BDW-1:0] bd_q;
  logic           restart;
  logic           pre_en;
  logic           smp_strobe;

  baud_cfg_watch #(.CDW(CDW), .BDW(BDW)) u_watch (
    .clk(clk), .rst(rst), .sel_in(pre_div8), .cd_in(clk_div), .bd_in(bit_div),
    .sel_q(sel_q), .cd_q(cd_q), .bd_q(bd_q), .restart(restart)
  );

  baud_prescale #(.RATIO(RATIO)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .sel(sel_q), .pre_en(pre_en)
  );

  baud_sample_div #(.CDW(CDW)) u_smp (
    .clk(clk), .rst(rst), .restart(restart), .pre_en(pre_en), .cd_q(cd_q),
    .strobe(smp_strobe), .tick(sample_tick)
  );

  baud_bit_div #(.BDW(BDW)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .strobe(smp_strobe), .bd_q(bd_q),
    .tick(bit_tick)
  );

  // R4: a bit strobe always lands on a sample strobe
  assert_bit_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  // R6: a divisor below two yields no strobe after the next edge
  assert_small_div_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (clk_div < CDW'(MIN_CLK_DIV)) |=> (!sample_tick && !bit_tick));

  // R7: the edge that takes a new setting emits no strobe
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_div8 = 1'b0;
  logic [15:0] clk_div = 16'd4;
  logic [7:0]  bit_div = 8'd4;
  logic        sample_tick;
  logic        bit_tick;

  int n_chk = 0;
  int n_bad = 0;
  int last_wide = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst(rst), .pre_div8(pre_div8), .clk_div(clk_div),
    .bit_div(bit_div), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // reset with new settings; returns at the negedge after the reset edge
  task automatic start_reset(input bit p, input int cd, input int bd);
    @(negedge clk);
    pre_div8 = p; clk_div = 16'(cd); bit_div = 8'(bd); rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // change settings without reset; returns at the negedge after the restart edge
  task automatic start_change(input bit p, input int cd, input int bd);
    @(negedge clk);
    pre_div8 = p; clk_div = 16'(cd); bit_div = 8'(bd);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic observe(input bit p, input int cd, input int bd, input int win,
                         input string rq_s, input string rq_b);
    int per;
    int bad_s = 0, bad_b = 0;
    int cyc_s = 0, cyc_b = 0, act_s = 0, exp_s = 0, act_b = 0, exp_b = 0;
    bit prev = 1'b0;
    per = p ? 8 * cd : cd;
    last_wide = 0;
    for (int n = 1; n <= win; n++) begin
      bit es, eb;
      @(posedge clk);
      @(negedge clk);
      es = 1'b0;
      if (cd >= 2) es = (n % per) == 0;
      eb = es && (((n / per) % (bd + 1)) == 0);
      if (sample_tick !== es) begin
        if (bad_s == 0) begin cyc_s = n; act_s = int'(sample_tick); exp_s = int'(es); end
        bad_s++;
      end
      if (bit_tick !== eb) begin
        if (bad_b == 0) begin cyc_b = n; act_b = int'(bit_tick); exp_b = int'(eb); end
        bad_b++;
      end
      if (prev && sample_tick) last_wide++;
      prev = sample_tick;
    end
    check(bad_s == 0, rq_s, $sformatf("sample_tick at cycle %0d (cd=%0d pre=%0d)", cyc_s, cd, p), act_s, exp_s);
    check(bad_b == 0, rq_b, $sformatf("bit_tick at cycle %0d (cd=%0d bd=%0d)", cyc_b, cd, bd), act_b, exp_b);
  endtask

  task automatic test_reset;
    @(negedge clk);
    pre_div8 = 1'b0; clk_div = 16'd4; bit_div = 8'd4; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1", "strobes low in reset",
          int'(sample_tick) + 2 * int'(bit_tick), 0);
    rst = 1'b0;
    observe(1'b0, 4, 4, 40, "R1", "R1");
  endtask

  task automatic test_plain;
    start_reset(1'b0, 3, 4);
    observe(1'b0, 3, 4, 45, "R2", "R4");
  endtask

  task automatic test_fastest;
    start_reset(1'b0, 2, 0);
    observe(1'b0, 2, 0, 20, "R5", "R4");
    check(last_wide == 0, "R5", "back-to-back sample strobes", last_wide, 0);
  endtask

  task automatic test_prescale;
    start_reset(1'b1, 3, 4);
    observe(1'b1, 3, 4, 240, "R3", "R3");
  endtask

  task automatic test_small_div;
    start_reset(1'b0, 0, 2);
    observe(1'b0, 0, 2, 100, "R6", "R6");
    start_change(1'b0, 1, 2);
    observe(1'b0, 1, 2, 100, "R6", "R6");
  endtask

  task automatic test_restart;
    start_reset(1'b0, 5, 4);
    observe(1'b0, 5, 4, 13, "R2", "R4");
    start_change(1'b0, 7, 4);
    observe(1'b0, 7, 4, 70, "R7", "R7");
    start_change(1'b0, 7, 5);
    observe(1'b0, 7, 5, 84, "R7", "R7");
    start_change(1'b1, 7, 5);
    observe(1'b1, 7, 5, 336, "R7", "R7");
  endtask

  task automatic test_extremes;
    start_reset(1'b0, 2, 255);
    observe(1'b0, 2, 255, 1024, "R8", "R8");
    start_change(1'b0, 65535, 4);
    observe(1'b0, 65535, 4, 65540, "R8", "R8");
  endtask

  initial begin
    test_reset();
    test_plain();
    test_fastest();
    test_prescale();
    test_small_div();
    test_restart();
    test_extremes();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule